// File: doc/BRIEF.md
# Timer Event Flag Register

This block is an 8-bit, bus-mapped status register. It collects the event pulses raised by three timers: compare matches, overflows and one input capture. Each implemented bit is a sticky flag. A one-cycle event pulse from a timer sets the flag. The flag stays set until software clears it by writing a one to that bit, or until the interrupt controller acknowledges the vector tied to that flag.

Each flag is also combined with its own enable bit and with one global interrupt-enable bit to drive a request line for that source. The enables come from elsewhere as plain inputs. The timers and the vector arbitration are also outside the block.

The overflow flags take either of two event pulses from their timer. In the normal modes the flag follows the wrap pulse. When a timer that supports up/down counting is in that mode, the flag instead follows the pulse that marks the count turning at zero. A parameter says which timers support up/down counting.

Top module: `tflag_reg`

## Requirements
- R1: A one-cycle event pulse sets its flag, and the flag is visible on the next cycle. Flag positions are: bit 7 compare timer2, bit 6 overflow timer2, bit 5 capture timer1, bit 4 compare timer1 channel A, bit 3 compare timer1 channel B, bit 2 overflow timer1, bit 0 overflow timer0. Non-overflow events enter on `src_evt` at these same bit positions.
- R2: A bus write to address `REG_ADDR` (default 0x38) clears, on the next cycle, every flag whose write-data bit is one.
- R3: Write-data bits that are zero leave their flags unchanged.
- R4: A one on `ack[i]` clears flag i on the next cycle.
- R5: If a set pulse and a clear (a write of one, an acknowledge, or both) hit the same flag in the same cycle, the flag ends up set.
- R6: `irq_req[i]` is high exactly when `global_ie`, `irq_en[i]` and flag i are all high. This holds for bits 7, 6, 4, 3, 2 and 0.
- R7: The capture flag (bit 5) never raises a request; `irq_req[5]` stays 0.
- R8: For timers 1 and 2 (`UPDOWN_MASK` bits 1 and 2), the overflow flag is set by `tmr_turn[k]` when `tmr_updown[k]` is 1, and by `tmr_wrap[k]` when it is 0; the pulse that is not selected is ignored. Timer 0 always uses `tmr_wrap[0]`.
- R9: Bit 1 is reserved. It reads 0, and writes, `src_evt[1]` and `ack[1]` have no effect on it.
- R10: While reset is held, and after it is released, all flags read 0.
- R11: When `bus_addr` differs from `REG_ADDR`, `bus_rdata` is 0 and writes leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; ones clear the matching flags |
| bus_rdata | output | 8 | Flag contents when the address matches, else 0 |
| src_evt | input | 8 | Compare and capture event pulses, one bit per flag position |
| tmr_wrap | input | 3 | Per-timer wraparound pulse |
| tmr_turn | input | 3 | Per-timer pulse when the count turns at zero |
| tmr_updown | input | 3 | Per-timer up/down counting mode |
| ack | input | 8 | Vector acknowledge, one bit per flag |
| irq_en | input | 8 | Per-source enable |
| global_ie | input | 1 | Global interrupt enable |
| irq_req | output | 8 | Per-source interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit address, the register at 0x38, and up/down support on timers 1 and 2 only. These defaults exercise both overflow sources on the timers that can turn at zero. They also exercise the fixed wrap-only path on timer 0, where a turn pulse must be ignored even when its mode input is high. The matching address and a foreign address (0x10) are both driven, so the read gating and the write decode are each tested both ways.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
   localparam int REG_W   = 8;
   localparam int NUM_TMR = 3;

   localparam int BIT_OVF0  = 0;
   localparam int BIT_RSVD  = 1;
   localparam int BIT_OVF1  = 2;
   localparam int BIT_CMP1B = 3;
   localparam int BIT_CMP1A = 4;
   localparam int BIT_CAP1  = 5;
   localparam int BIT_OVF2  = 6;
   localparam int BIT_CMP2  = 7;

   // bits that hold a real flag
   localparam logic [REG_W-1:0] IMPL_MASK = 8'b1111_1101;
   // bits whose set event comes straight from src_evt
   localparam logic [REG_W-1:0] DIRECT_MASK = 8'b1011_1000;
   // bits that own a request line
   localparam logic [REG_W-1:0] REQ_MASK = 8'b1101_1101;

   function automatic int ovf_bit(input int tmr);
      case (tmr)
         0:       return BIT_OVF0;
         1:       return BIT_OVF1;
         default: return BIT_OVF2;
      endcase
   endfunction
endpackage

// File: rtl/tflag_ovf_sel.sv
module tflag_ovf_sel #(
   parameter bit UPDOWN_OK = 1'b1
) (
   input  logic wrap_evt,
   input  logic turn_evt,
   input  logic updown,
   output logic ovf_evt
);
   generate
      if (UPDOWN_OK) begin : g_dual
         assign ovf_evt = updown ? turn_evt : wrap_evt;
      end else begin : g_wrap_only
         logic unused_sel;
         assign unused_sel = turn_evt ^ updown;
         assign ovf_evt    = wrap_evt;
      end
   endgenerate
endmodule

// File: rtl/tflag_cell.sv
module tflag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic wr_clr,
   input  logic ack_clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (set_evt)          flag <= 1'b1;
      else if (wr_clr | ack_clr) flag <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag); // R5
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !set_evt) |=> !flag); // R2
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr && !set_evt) |=> !flag); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt && !wr_clr && !ack_clr) |=> $stable(flag)); // R3
endmodule

// File: rtl/tflag_bus.sv
module tflag_bus
   import tflag_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] REG_ADDR = 6'h38
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic [REG_W-1:0]  flags,
   output logic [REG_W-1:0]  wr_clr,
   output logic [REG_W-1:0]  bus_rdata
);
   logic hit;
   assign hit = (bus_addr == REG_ADDR);

   always_comb begin
      wr_clr    = '0;
      bus_rdata = '0;
      if (hit) begin
         bus_rdata = flags & IMPL_MASK;
         if (bus_we) wr_clr = bus_wdata & IMPL_MASK;
      end
   end

   always_comb begin
      if (!hit) AST_FOREIGN_QUIET: assert (bus_rdata == '0 && wr_clr == '0); // R11
   end
endmodule

// File: rtl/tflag_irq.sv
module tflag_irq
   import tflag_pkg::*;
(
   input  logic [REG_W-1:0] flags,
   input  logic [REG_W-1:0] irq_en,
   input  logic             global_ie,
   output logic [REG_W-1:0] irq_req
);
   always_comb begin
      irq_req = '0;
      for (int b = 0; b < REG_W; b++) begin
         if (REQ_MASK[b]) irq_req[b] = global_ie & irq_en[b] & flags[b];
      end
   end
endmodule

// File: rtl/tflag_reg.sv
module tflag_reg
   import tflag_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] REG_ADDR = 6'h38,
   parameter logic [NUM_TMR-1:0] UPDOWN_MASK = 3'b110
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [REG_W-1:0]   src_evt,
   input  logic [NUM_TMR-1:0] tmr_wrap,
   input  logic [NUM_TMR-1:0] tmr_turn,
   input  logic [NUM_TMR-1:0] tmr_updown,
   input  logic [REG_W-1:0]   ack,
   input  logic [REG_W-1:0]   irq_en,
   input  logic               global_ie,
   output logic [REG_W-1:0]   irq_req
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("tflag_reg: ADDR_W out of range");
      end
      if (int'(REG_ADDR) >= ADDR_SPAN) begin : g_bad_addr
         $error("tflag_reg: REG_ADDR beyond address space");
      end
   endgenerate

   logic [NUM_TMR-1:0] ovf_evt;
   logic [REG_W-1:0]   set_vec;
   logic [REG_W-1:0]   wr_clr;
   logic [REG_W-1:0]   flags;

   genvar k;
   generate
      for (k = 0; k < NUM_TMR; k++) begin : g_tmr
         tflag_ovf_sel #(.UPDOWN_OK(UPDOWN_MASK[k])) u_sel (
            .wrap_evt (tmr_wrap[k]),
            .turn_evt (tmr_turn[k]),
            .updown   (tmr_updown[k]),
            .ovf_evt  (ovf_evt[k])
         );
      end
   endgenerate

   always_comb begin
      set_vec = src_evt & DIRECT_MASK;
      for (int t = 0; t < NUM_TMR; t++) set_vec[ovf_bit(t)] = ovf_evt[t];
   end

   genvar b;
   generate
      for (b = 0; b < REG_W; b++) begin : g_bit
         if (IMPL_MASK[b]) begin : g_flag
            tflag_cell u_cell (
               .clk     (clk),
               .rst_n   (rst_n),
               .set_evt (set_vec[b]),
               .wr_clr  (wr_clr[b]),
               .ack_clr (ack[b]),
               .flag    (flags[b])
            );
         end else begin : g_rsvd
            assign flags[b] = 1'b0;
         end
      end
   endgenerate

   logic unused_rsvd;
   assign unused_rsvd = ^{set_vec[BIT_RSVD], wr_clr[BIT_RSVD], ack[BIT_RSVD]};

   tflag_bus #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .flags     (flags),
      .wr_clr    (wr_clr),
      .bus_rdata (bus_rdata)
   );

   tflag_irq u_irq (
      .flags     (flags),
      .irq_en    (irq_en),
      .global_ie (global_ie),
      .irq_req   (irq_req)
   );

   AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req != '0) |-> global_ie); // R6
   AST_NO_CAPTURE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[BIT_CAP1] |=> !irq_req[BIT_CAP1]); // R7
   AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata[BIT_RSVD]) |=> !bus_rdata[BIT_RSVD]); // R9
endmodule

// File: tb/sim_tflag_reg.sv
`timescale 1ns/1ps
module sim_tflag_reg;
   localparam logic [5:0] ADDR_HIT  = 6'h38;
   localparam logic [5:0] ADDR_MISS = 6'h10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = ADDR_HIT;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] src_evt = '0;
   logic [2:0] tmr_wrap = '0, tmr_turn = '0, tmr_updown = '0;
   logic [7:0] ack = '0, irq_en = '0;
   logic       global_ie = 1'b0;
   logic [7:0] irq_req;

   always #2.5 clk = ~clk;

   tflag_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
      .tmr_wrap(tmr_wrap), .tmr_turn(tmr_turn), .tmr_updown(tmr_updown),
      .ack(ack), .irq_en(irq_en), .global_ie(global_ie), .irq_req(irq_req)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R10";
   int    model [8];

   task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model_vec();
      logic [7:0] v = '0;
      for (int i = 0; i < 8; i++) v[i] = (model[i] != 0);
      return v;
   endfunction

   task automatic model_step();
      int sets [8];
      int clrs [8];
      int tpos [3] = '{0, 2, 6};
      for (int i = 0; i < 8; i++) begin
         sets[i] = (i == 7 || i == 5 || i == 4 || i == 3) ? int'(src_evt[i]) : 0;
         clrs[i] = int'(ack[i]);
         if (bus_we && bus_addr == ADDR_HIT && bus_wdata[i]) clrs[i] = 1;
      end
      for (int t = 0; t < 3; t++) begin
         if (t > 0 && tmr_updown[t]) sets[tpos[t]] = int'(tmr_turn[t]);
         else                        sets[tpos[t]] = int'(tmr_wrap[t]);
      end
      for (int i = 0; i < 8; i++) begin
         if (i == 1)             model[i] = 0;
         else if (sets[i] != 0)  model[i] = 1;
         else if (clrs[i] != 0)  model[i] = 0;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) model_step();
      else for (int i = 0; i < 8; i++) model[i] = 0;
      @(negedge clk);
      check8(cur_req, "rdata", bus_rdata, (bus_addr == ADDR_HIT) ? model_vec() : 8'h00);
      check8(cur_req, "irq", irq_req,
             global_ie ? (model_vec() & irq_en & 8'b1101_1101) : 8'h00);
   endtask

   task automatic quiet();
      bus_we = 0; bus_wdata = '0; src_evt = '0; ack = '0;
      tmr_wrap = '0; tmr_turn = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 0;
      // R10: reset state
      cur_req = "R10";
      repeat (3) tick();
      check8("R10", "rdata in reset", bus_rdata, 8'h00);
      rst_n = 1'b1;
      tick();
      check8("R10", "rdata after reset", bus_rdata, 8'h00);

      // R1: each source sets its own bit
      cur_req = "R1";
      src_evt[7] = 1; tick(); quiet(); tick();
      check8("R1", "compare timer2", bus_rdata, 8'h80);
      src_evt[5] = 1; src_evt[4] = 1; tick(); quiet();
      src_evt[3] = 1; tmr_wrap = 3'b111; tick(); quiet(); tick();
      check8("R1", "all flags", bus_rdata, 8'hFD);

      // R2: write one clears
      cur_req = "R2";
      bus_we = 1; bus_wdata = 8'h30; tick(); quiet(); tick();
      check8("R2", "w1c", bus_rdata, 8'hCD);

      // R3: write zero keeps
      cur_req = "R3";
      bus_we = 1; bus_wdata = 8'h00; tick(); quiet(); tick();
      check8("R3", "w0 keeps", bus_rdata, 8'hCD);

      // R4: acknowledge clears
      cur_req = "R4";
      ack = 8'h80; tick(); quiet(); tick();
      check8("R4", "ack clear", bus_rdata, 8'h4D);

      // R5: set beats clear
      cur_req = "R5";
      src_evt[3] = 1; bus_we = 1; bus_wdata = 8'h08; ack = 8'h08; tick(); quiet(); tick();
      check8("R5", "set vs clear", bus_rdata, 8'h4D);
      tmr_wrap[0] = 1; ack = 8'h01; tick(); quiet(); tick();
      check8("R5", "set vs ack", bus_rdata, 8'h4D);

      // R6: request gating
      cur_req = "R6";
      irq_en = 8'hFF; global_ie = 0; tick();
      check8("R6", "gie off", irq_req, 8'h00);
      global_ie = 1; tick();
      check8("R6", "gie on", irq_req, 8'h4D);
      irq_en = 8'h40; tick();
      check8("R6", "single enable", irq_req, 8'h40);

      // R7: capture has no request
      cur_req = "R7";
      irq_en = 8'hFF; src_evt[5] = 1; tick(); quiet(); tick();
      check8("R7", "capture flag", bus_rdata, 8'h6D);
      check8("R7", "capture irq", irq_req, 8'h4D);

      // R9: reserved bit
      cur_req = "R9";
      bus_we = 1; bus_wdata = 8'hFF; tick(); quiet(); tick();
      check8("R9", "all cleared", bus_rdata, 8'h00);
      src_evt[1] = 1; ack[1] = 1; tick(); quiet(); tick();
      check8("R9", "rsvd ignores", bus_rdata, 8'h00);

      // R8: up/down overflow source
      cur_req = "R8";
      tmr_updown = 3'b010; tmr_wrap[1] = 1; tick(); quiet(); tick();
      check8("R8", "wrap ignored", bus_rdata, 8'h00);
      tmr_turn[1] = 1; tick(); quiet(); tick();
      check8("R8", "turn sets", bus_rdata, 8'h04);
      tmr_updown = 3'b001; tmr_turn[0] = 1; tick(); quiet(); tick();
      check8("R8", "timer0 turn ignored", bus_rdata, 8'h04);
      tmr_wrap[0] = 1; tick(); quiet(); tick();
      check8("R8", "timer0 wrap", bus_rdata, 8'h05);
      tmr_updown = 3'b000; tmr_turn[2] = 1; tick(); quiet(); tick();
      check8("R8", "timer2 turn ignored", bus_rdata, 8'h05);
      tmr_updown = 3'b100; tmr_turn[2] = 1; tick(); quiet(); tick();
      check8("R8", "timer2 turn", bus_rdata, 8'h45);

      // R11: foreign address
      cur_req = "R11";
      bus_addr = ADDR_MISS; tick();
      check8("R11", "miss read", bus_rdata, 8'h00);
      bus_we = 1; bus_wdata = 8'hFF; tick(); quiet(); bus_addr = ADDR_HIT; tick();
      check8("R11", "miss write", bus_rdata, 8'h45);

      // mixed traffic against the model
      cur_req = "R1";
      for (int n = 0; n < 400; n++) begin
         bus_addr   = ($urandom % 4 == 0) ? ADDR_MISS : ADDR_HIT;
         bus_we     = ($urandom % 4 == 0);
         bus_wdata  = 8'($urandom);
         src_evt    = 8'($urandom) & 8'($urandom);
         ack        = 8'($urandom) & 8'($urandom) & 8'($urandom);
         tmr_wrap   = 3'($urandom) & 3'($urandom);
         tmr_turn   = 3'($urandom) & 3'($urandom);
         tmr_updown = 3'($urandom);
         irq_en     = 8'($urandom);
         global_ie  = ($urandom % 3 != 0);
         tick();
      end
      quiet();
      tick();
      finish_run();
   end
endmodule